// File: doc/BRIEF.md
# CPU PLL Relock Sequencer with Clock Parking

This block changes the multiplier and divider settings of a CPU PLL while the core keeps running. On a start pulse it moves the core clock mux onto a second PLL that is already stable. It waits until the mux reports that the switch has finished. It then programs the PLL relock timer and writes the new settings into the PLL control word. It waits for the PLL to report lock, moves the mux back to the main PLL and waits for that switch to be confirmed. The analog PLL, the glitch-free mux and the register bus are outside the block. They appear only as status inputs and as write strobes with data.

The new settings arrive as one 32-bit packed word. The block builds the control-register write from that word and from the current register contents, so bits it does not own are kept. The relock time is derived from the input divider field of the packed word. Each waiting step can be bounded by a timeout that abandons the sequence and reports an error.

Top module: `pll_relock_seq`

## Requirements
- R1: While reset is asserted and right after it is released, mux_sel_o is 0 (main PLL) and busy_o, done_o, err_o, lock_time_wr_o and ctrl_wr_o are all 0.
- R2: A start_i pulse sampled while idle sets mux_sel_o to 1 (alternate PLL) and busy_o to 1 on the next cycle. The packed word is captured at that edge.
- R3: The park step completes only when mux_stat_i equals 2. Any other value keeps the sequencer waiting, with no write strobe.
- R4: In the cycle after park is confirmed, lock_time_wr_o pulses for exactly one cycle with lock_time_o equal to the input divider field times 250. The input divider field is bits 13:8 of the packed word.
- R5: In the cycle after the lock-time strobe, ctrl_wr_o pulses for one cycle. ctrl_wdata_o takes bits 25:16 (multiplier), 13:8 (input divider) and 2:0 (output divider) from the packed word, which is mask 0x03FF3F07. All other bits are taken from ctrl_cur_i.
- R6: pll_locked_i is ignored until the cycle after the control write. mux_sel_o stays 1 until pll_locked_i is sampled high in the lock-wait step, and drops to 0 on the next edge.
- R7: The return step completes only when mux_stat_i equals 1. done_o then pulses for one cycle and busy_o falls in the same cycle.
- R8: A start_i pulse while busy is ignored. No extra write and no extra done is produced, and the captured word is not replaced.
- R9: If a waiting step (park, lock or return) is unsatisfied for TIMEOUT_CYC consecutive cycles, err_o pulses once and busy_o falls. No done pulse and no further write follows, and mux_sel_o keeps its value. A TIMEOUT_CYC of 0 disables the timeout.
- R10: Bits of the packed word outside the three fields have no effect on ctrl_wdata_o or lock_time_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a relock sequence |
| pms_word_i | input | 32 | Packed multiplier and divider settings |
| ctrl_cur_i | input | 32 | Current contents of the PLL control register |
| mux_stat_i | input | 3 | Core clock mux status (2 = on alternate, 1 = on main) |
| pll_locked_i | input | 1 | Lock indication of the main PLL |
| mux_sel_o | output | 1 | Mux select: 1 alternate PLL, 0 main PLL |
| lock_time_o | output | LOCK_W | Relock timer value |
| lock_time_wr_o | output | 1 | Write strobe for lock_time_o |
| ctrl_wdata_o | output | 32 | New PLL control register value |
| ctrl_wr_o | output | 1 | Write strobe for ctrl_wdata_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence completes |
| err_o | output | 1 | One-cycle pulse when a wait step times out |

## Verification
The bench holds the mux status at values other than the confirming ones while a switch is pending. A design that accepted any change of status would write the lock time early, or raise done before the core is back on the main PLL. It keeps the lock flag high from before the control write. A design that sampled it too early would release the mux one cycle after the write, before the PLL has relocked. It also sends a packed word with every non-field bit set and uses divider values 0 and 63, which expose a merge that is too wide or a product that is truncated. It retriggers start mid-sequence and stalls each wait step in turn. A design that restarts would emit extra writes. A design with a timeout that is off by one, or that completes the sequence anyway, would show a misplaced error or a spurious done.

// File: rtl/pll_relock_pkg.sv
package pll_relock_pkg;

    localparam int WORD_W = 32;

    // field placement inside the packed settings word and the control register
    localparam int M_LSB = 16;
    localparam int M_W   = 10;
    localparam int P_LSB = 8;
    localparam int P_W   = 6;
    localparam int S_LSB = 0;
    localparam int S_W   = 3;

    localparam logic [WORD_W-1:0] FIELD_MASK =
        (WORD_W'((1 << M_W) - 1) << M_LSB) |
        (WORD_W'((1 << P_W) - 1) << P_LSB) |
        (WORD_W'((1 << S_W) - 1) << S_LSB);

    // mux status codes that confirm a completed switch
    localparam logic [2:0] MUX_ON_ALT  = 3'd2;
    localparam logic [2:0] MUX_ON_MAIN = 3'd1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PARK   = 3'd1,
        ST_LOCKT  = 3'd2,
        ST_WRPMS  = 3'd3,
        ST_WLOCK  = 3'd4,
        ST_RETURN = 3'd5
    } seq_state_e;

endpackage

// File: rtl/pll_relock_calc.sv
module pll_relock_calc
    import pll_relock_pkg::*;
#(
    parameter int LOCK_MULT = 250,
    parameter int LOCK_W    = 16
) (
    input  logic [WORD_W-1:0] pms_i,
    input  logic [WORD_W-1:0] cur_i,
    output logic [LOCK_W-1:0] lock_time_o,
    output logic [WORD_W-1:0] merged_o
);

    logic [LOCK_W-1:0] p_ext;

    always_comb begin
        p_ext       = LOCK_W'(pms_i[P_LSB +: P_W]);
        lock_time_o = p_ext * LOCK_W'(LOCK_MULT);
        merged_o    = (cur_i & ~FIELD_MASK) | (pms_i & FIELD_MASK);
    end

endmodule

// File: rtl/pll_relock_timer.sv
module pll_relock_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(LIMIT + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'((LIMIT > 0) ? LIMIT - 1 : 0);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired_o = (LIMIT > 0) && run_i && (cnt_q == LAST);
        if (!run_i || expired_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (LIMIT > 0) begin : g_bound_chk
            assert_timer_bounded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
                cnt_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/pll_relock_seq.sv
module pll_relock_seq
    import pll_relock_pkg::*;
#(
    parameter int LOCK_MULT   = 250,
    parameter int LOCK_W      = 16,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [WORD_W-1:0] pms_word_i,
    input  logic [WORD_W-1:0] ctrl_cur_i,
    input  logic [2:0]        mux_stat_i,
    input  logic              pll_locked_i,
    output logic              mux_sel_o,
    output logic [LOCK_W-1:0] lock_time_o,
    output logic              lock_time_wr_o,
    output logic [WORD_W-1:0] ctrl_wdata_o,
    output logic              ctrl_wr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        seq_state_e        st;
        logic              mux_sel;
        logic              busy;
        logic              done;
        logic              err;
        logic              lock_wr;
        logic              ctrl_wr;
        logic [LOCK_W-1:0] lock_time;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] pms;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [LOCK_W-1:0] calc_lock;
    logic [WORD_W-1:0] calc_word;
    logic              wait_run;
    logic              tmo;

    pll_relock_calc #(
        .LOCK_MULT (LOCK_MULT),
        .LOCK_W    (LOCK_W)
    ) u_calc (
        .pms_i       (r_q.pms),
        .cur_i       (ctrl_cur_i),
        .lock_time_o (calc_lock),
        .merged_o    (calc_word)
    );

    // the timeout counter runs only while a wait step is still unsatisfied
    always_comb begin
        wait_run = ((r_q.st == ST_PARK)   && (mux_stat_i != MUX_ON_ALT))  ||
                   ((r_q.st == ST_WLOCK)  && !pll_locked_i)               ||
                   ((r_q.st == ST_RETURN) && (mux_stat_i != MUX_ON_MAIN));
    end

    pll_relock_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (wait_run),
        .expired_o (tmo)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.err     = 1'b0;
        r_d.lock_wr = 1'b0;
        r_d.ctrl_wr = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st      = ST_PARK;
                    r_d.mux_sel = 1'b1;
                    r_d.busy    = 1'b1;
                    r_d.pms     = pms_word_i;
                end
            end
            ST_PARK: begin
                if (mux_stat_i == MUX_ON_ALT) begin
                    r_d.st        = ST_LOCKT;
                    r_d.lock_wr   = 1'b1;
                    r_d.lock_time = calc_lock;
                end else if (tmo) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end
            end
            ST_LOCKT: begin
                r_d.st      = ST_WRPMS;
                r_d.ctrl_wr = 1'b1;
                r_d.wdata   = calc_word;
            end
            ST_WRPMS: begin
                r_d.st = ST_WLOCK;
            end
            ST_WLOCK: begin
                if (pll_locked_i) begin
                    r_d.st      = ST_RETURN;
                    r_d.mux_sel = 1'b0;
                end else if (tmo) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end
            end
            ST_RETURN: begin
                if (mux_stat_i == MUX_ON_MAIN) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.done = 1'b1;
                end else if (tmo) begin
                    r_d.st   = ST_IDLE;
                    r_d.busy = 1'b0;
                    r_d.err  = 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.busy = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mux_sel_o      = r_q.mux_sel;
    assign lock_time_o    = r_q.lock_time;
    assign lock_time_wr_o = r_q.lock_wr;
    assign ctrl_wdata_o   = r_q.wdata;
    assign ctrl_wr_o      = r_q.ctrl_wr;
    assign busy_o         = r_q.busy;
    assign done_o         = r_q.done;
    assign err_o          = r_q.err;

    assert_park_confirm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.lock_wr |-> $past(mux_stat_i == MUX_ON_ALT));

    assert_strobe_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({r_q.lock_wr, r_q.ctrl_wr, r_q.done, r_q.err}));

    assert_ctrl_follows_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.lock_wr |=> r_q.ctrl_wr);

    assert_release_on_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(r_q.mux_sel) |-> $past(pll_locked_i));

    assert_done_on_main_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.done |-> (!r_q.mux_sel && !r_q.busy && $past(mux_stat_i == MUX_ON_MAIN)));

    assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.busy && start_i) |=> $stable(r_q.pms));

    assert_err_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.err |-> (!r_q.busy && !r_q.done));

endmodule

// File: tb/pll_relock_seq_tb.sv
`timescale 1ns/1ps
module pll_relock_seq_tb;

    localparam int LOCK_W = 16;
    localparam int TMO    = 40;
    localparam logic [31:0] MASK = 32'h03FF_3F07;
    localparam logic [1:0] K_LOCK = 2'd0, K_CTRL = 2'd1, K_DONE = 2'd2, K_ERR = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] val;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] pms_word = '0;
    logic [31:0] ctrl_cur = '0;
    logic [2:0]  mux_stat = 3'd1;
    logic        pll_locked = 1'b0;
    logic        mux_sel_o, lock_time_wr_o, ctrl_wr_o, busy_o, done_o, err_o;
    logic [LOCK_W-1:0] lock_time_o;
    logic [31:0] ctrl_wdata_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    pll_relock_seq #(
        .LOCK_MULT   (250),
        .LOCK_W      (LOCK_W),
        .TIMEOUT_CYC (TMO)
    ) u_dut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .start_i        (start),
        .pms_word_i     (pms_word),
        .ctrl_cur_i     (ctrl_cur),
        .mux_stat_i     (mux_stat),
        .pll_locked_i   (pll_locked),
        .mux_sel_o      (mux_sel_o),
        .lock_time_o    (lock_time_o),
        .lock_time_wr_o (lock_time_wr_o),
        .ctrl_wdata_o   (ctrl_wdata_o),
        .ctrl_wr_o      (ctrl_wr_o),
        .busy_o         (busy_o),
        .done_o         (done_o),
        .err_o          (err_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: every strobe must match the next expected item
    always @(negedge clk) begin : monitor
        exp_t got;
        exp_t e;
        if (rst_n && !finished && (lock_time_wr_o || ctrl_wr_o || done_o || err_o)) begin
            chk($countones({lock_time_wr_o, ctrl_wr_o, done_o, err_o}) == 1, "R4 one strobe at a time",
                32'($countones({lock_time_wr_o, ctrl_wr_o, done_o, err_o})), 32'd1);
            if (lock_time_wr_o)     got = '{kind: K_LOCK, val: 32'(lock_time_o)};
            else if (ctrl_wr_o)     got = '{kind: K_CTRL, val: ctrl_wdata_o};
            else if (done_o)        got = '{kind: K_DONE, val: 32'd0};
            else                    got = '{kind: K_ERR,  val: 32'd0};
            if (ctrl_wr_o) chk(mux_sel_o == 1'b1, "R6 still parked at write", 32'(mux_sel_o), 32'd1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected strobe", {30'd0, got.kind}, 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                chk(got.kind == e.kind, "R4/R5/R7/R9 strobe kind", {30'd0, got.kind}, {30'd0, e.kind});
                chk(got.val == e.val, "R4/R5/R10 strobe value", got.val, e.val);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input logic [31:0] pms, input logic [31:0] cur, input int park_wait,
                           input int lock_wait, input int ret_wait, input bit stale, input bit poke);
        exp_q.push_back('{kind: K_LOCK, val: 32'(pms[13:8]) * 32'd250});
        exp_q.push_back('{kind: K_CTRL, val: (cur & ~MASK) | (pms & MASK)});
        exp_q.push_back('{kind: K_DONE, val: 32'd0});
        ctrl_cur = cur; pll_locked = stale; mux_stat = 3'd1;
        tick();
        start = 1'b1; pms_word = pms;
        tick();
        start = 1'b0; pms_word = ~pms;
        chk(mux_sel_o && busy_o, "R2 parked and busy", {30'd0, mux_sel_o, busy_o}, 32'd3);
        for (int i = 0; i < park_wait; i++) begin
            mux_stat = (i % 2 == 0) ? 3'd3 : 3'd1;
            chk(!lock_time_wr_o, "R3 no write before park confirm", 32'(lock_time_wr_o), 32'd0);
            tick();
        end
        mux_stat = 3'd2;
        for (int i = 0; i < 10 && !ctrl_wr_o; i++) tick();
        chk(ctrl_wr_o, "R5 control write seen", 32'(ctrl_wr_o), 32'd1);
        if (poke) begin
            start = 1'b1; pms_word = 32'h0;
        end
        pll_locked = 1'b0;
        for (int i = 0; i < lock_wait; i++) begin
            tick();
            start = 1'b0;
            chk(mux_sel_o, "R6 held until lock", 32'(mux_sel_o), 32'd1);
        end
        pll_locked = 1'b1;
        tick();
        chk(!mux_sel_o, "R6 released after lock", 32'(mux_sel_o), 32'd0);
        mux_stat = 3'd2;
        for (int i = 0; i < ret_wait; i++) begin
            chk(!done_o && busy_o, "R7 waits for main confirm", {30'd0, done_o, busy_o}, 32'd1);
            tick();
        end
        mux_stat = 3'd1;
        tick();
        chk(done_o && !busy_o, "R7 done pulse", {30'd0, done_o, busy_o}, 32'd2);
        tick();
        chk(!done_o, "R7 done is single cycle", 32'(done_o), 32'd0);
        repeat (4) tick();
        chk(exp_q.size() == 0, "R8 all expected strobes seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic run_timeout(input int stage);
        int n;
        logic [31:0] pms;
        pms = {6'd0, 10'd100, 2'd0, 6'd3, 5'd0, 3'd1};
        ctrl_cur = 32'h0000_0000; pll_locked = 1'b0; mux_stat = 3'd1;
        if (stage >= 1) begin
            exp_q.push_back('{kind: K_LOCK, val: 32'd750});
            exp_q.push_back('{kind: K_CTRL, val: pms & MASK});
        end
        exp_q.push_back('{kind: K_ERR, val: 32'd0});
        tick();
        start = 1'b1; pms_word = pms;
        tick();
        start = 1'b0;
        if (stage == 0) begin
            n = 0;
            while (!err_o && n < TMO + 5) begin tick(); n++; end
            chk(n == TMO, "R9 park timeout cycle", 32'(n), 32'(TMO));
            chk(mux_sel_o && !busy_o, "R9 mux kept, idle", {30'd0, mux_sel_o, busy_o}, 32'd2);
        end else begin
            mux_stat = 3'd2;
            if (stage == 2) begin
                for (int i = 0; i < 10 && !ctrl_wr_o; i++) tick();
                pll_locked = 1'b1;
            end
            n = 0;
            while (!err_o && n < TMO + 20) begin tick(); n++; end
            chk(err_o, "R9 timeout error raised", 32'(err_o), 32'd1);
            chk(mux_sel_o == (stage == 1) && !busy_o, "R9 mux kept, idle",
                {30'd0, mux_sel_o, busy_o}, {30'd0, (stage == 1), 1'b0});
        end
        repeat (4) tick();
        chk(!done_o && exp_q.size() == 0, "R9 no done after error", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        chk(!mux_sel_o && !busy_o && !done_o && !err_o && !lock_time_wr_o && !ctrl_wr_o,
            "R1 reset state", {26'd0, mux_sel_o, busy_o, done_o, err_o, lock_time_wr_o, ctrl_wr_o}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk(!mux_sel_o && !busy_o, "R1 after release", {30'd0, mux_sel_o, busy_o}, 32'd0);

        // nominal: M=250 P=4 S=0
        run_seq({6'd0, 10'd250, 2'd0, 6'd4, 8'd0}, 32'h8000_0000, 3, 4, 2, 1'b0, 1'b0);
        // stale lock flag held high through the write, R6
        run_seq({6'd0, 10'd175, 2'd0, 6'd3, 8'd1}, 32'h0000_0000, 0, 3, 0, 1'b1, 1'b0);
        // R10: every non-field bit set, P at its maximum, other control bits kept
        run_seq(32'hFC00_C0F8 | {6'd0, 10'h3FF, 2'd0, 6'd63, 5'd0, 3'd7}, 32'hA5A5_A5A5, 1, 2, 1, 1'b0, 1'b0);
        // R4 boundary: P = 0 gives a zero lock time
        run_seq({6'd0, 10'd1, 2'd0, 6'd0, 5'd0, 3'd2}, 32'hFFFF_FFFF, 2, 1, 3, 1'b0, 1'b0);
        // R8: start retriggered mid-sequence
        run_seq({6'd0, 10'd325, 2'd0, 6'd6, 8'd0}, 32'h1234_5678, 1, 3, 1, 1'b0, 1'b1);

        run_timeout(0);
        run_timeout(1);
        run_timeout(2);
        // recovery after an error
        run_seq({6'd0, 10'd100, 2'd0, 6'd3, 5'd0, 3'd2}, 32'h0C00_00F0, 1, 1, 1, 1'b0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule